// File: doc/BRIEF.md
# SPI-Mode Memory Card Byte Responder

This block plays the card side of the SPI-mode memory card protocol, one byte at a time. A bit-level shifter presents each received byte together with a strobe. In the same cycle the engine returns the byte to shift out on that exchange. Commands, arguments, responses, read blocks and write blocks are all sequenced by one protocol state machine. Each data block read out carries a start token and a trailing CRC16 that the engine computes itself.

Behind the engine sits a storage back-end with three single-cycle handshakes, all answered combinationally in the strobe cycle. The first issues a command and returns ok/fail plus a 32-bit word. The second takes one read byte and reports whether data is available and whether this byte is the last one. The third hands over one write byte and reports whether this byte fills the back-end. Read and write transfers are split into blocks of `BLOCK_BYTES` bytes. The engine handles these protocol features:

- multi-block transfers, delimited by their own tokens;
- a stop command that aborts any read stage;
- busy padding after busy-type commands.

Top module: `mcard_spi_engine`

## Requirements
- R1: A synchronous reset, from any state, puts the engine in the command state. In that state a received 0xFF is answered 0xFF and issues nothing to the back-end.
- R2: In the command state, any byte other than 0xFF, 0xFE, 0xFC or 0xFD starts a command, with its low 6 bits as the index. Four argument bytes follow, most significant first. The next byte is a checksum slot: it is ignored, and it issues the command with that index and argument. Every byte of the frame is answered 0xFF.
- R3: A command the back-end fails gives a one-byte response of 0x04.
- R4: Commands 8 and 58, when successful, give five bytes: 0x01, then the 32-bit word from most to least significant byte.
- R5: Command 13 gives word bits 31:24 and then bits 23:16. Any other successful command gives word bits 31:24 only. Response bytes go out on the exchanges that follow the checksum slot.
- R6: After the response of a successful command 28, 29 or 38, one extra 0xFF is sent. The engine then returns to the command state even if read data is pending.
- R7: Once the response bytes are out, if read data is available, the engine sends 0xFF and then the token 0xFE, and then streams back-end bytes. Each block is followed by its CRC16, high byte first. The CRC uses polynomial 0x1021 with initial value 0, over the block's data bytes only.
- R8: A read block ends after `BLOCK_BYTES` bytes, or after the byte the back-end flags as last.
- R9: After the CRC, a block that reached `BLOCK_BYTES` under any command but 17 is followed by 0xFF, 0xFE and the next block. Otherwise the engine returns to the command state.
- R10: A byte 0x4C received in any read stage is answered 0xFF and reads nothing. It starts command 12. One 0xFF delay byte then precedes that command's response.
- R11: In the command state, 0xFE or 0xFC opens a write block. Each following byte is passed to the back-end and echoed, until `BLOCK_BYTES` bytes or the back-end's last-byte flag. Two checksum bytes are then answered 0xFF without being passed on, and the next byte returns 0x05.
- R12: In the command state, 0xFD issues command 12 with argument 0. The next byte returns 0xFF if the back-end reports ok and 0x00 if it reports busy (fail).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One received byte is presented this cycle |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to shift out for this exchange |
| be_cmd_req | output | 1 | Issue a command to the back-end |
| be_cmd_idx | output | 6 | Command index |
| be_cmd_arg | output | 32 | Command argument |
| be_cmd_ok | input | 1 | Command succeeded (low means fail or busy) |
| be_cmd_resp | input | 32 | Command response word |
| be_rd_req | output | 1 | Take one read byte |
| be_rd_data | input | 8 | Current read byte |
| be_rd_ready | input | 1 | Read data available |
| be_rd_last | input | 1 | Current read byte is the last available |
| be_wr_req | output | 1 | Store one write byte |
| be_wr_data | output | 8 | Write byte |
| be_wr_last | input | 1 | This write byte fills the back-end |

## Verification
Reads are tried with three lengths of available data. A length longer than one block under command 17 separates single-block from multi-block continuation. A short length under command 18 shows the last-byte end of a block. A length spanning two full blocks plus a remainder exercises the repeat path and the CRC restart per block. Writes are run as a full block and as a short block whose checksum bytes carry a value that would show if they were echoed. Response shapes are separated by word patterns whose bytes are all distinct. The stop byte is injected mid-block, and busy padding is checked with read data pending, so that it cannot be mistaken for the ordinary return to the command state.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;

    localparam logic [7:0] BYTE_IDLE      = 8'hFF;
    localparam logic [7:0] TOK_BLOCK      = 8'hFE;
    localparam logic [7:0] TOK_MULTI_WR   = 8'hFC;
    localparam logic [7:0] TOK_END_WR     = 8'hFD;
    localparam logic [7:0] BYTE_STOP_CMD  = 8'h4C;
    localparam logic [7:0] BYTE_WR_ACCEPT = 8'h05;
    localparam logic [7:0] BYTE_CMD_FAIL  = 8'h04;
    localparam logic [7:0] BYTE_LONG_HDR  = 8'h01;

    localparam logic [5:0] IDX_STOP      = 6'd12;
    localparam logic [5:0] IDX_STATUS    = 6'd13;
    localparam logic [5:0] IDX_IFCOND    = 6'd8;
    localparam logic [5:0] IDX_OCR       = 6'd58;
    localparam logic [5:0] IDX_SINGLE_RD = 6'd17;

    localparam int RESP_MAX = 5;
    localparam int RESP_W   = 8 * RESP_MAX;

    typedef enum logic [3:0] {
        M_CMD, M_ARG, M_RESP, M_PREP, M_START, M_READ, M_RDCRC, M_WRITE, M_WRCRC
    } mode_e;

    typedef struct packed {
        logic [RESP_W-1:0] bytes;
        logic [2:0]        len;
        logic              busy;
    } resp_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic is_busy_cmd(input logic [5:0] idx);
        return (idx == 6'd28) || (idx == 6'd29) || (idx == 6'd38);
    endfunction

endpackage

// File: rtl/mcs_resp_build.sv
`timescale 1ns/1ps
module mcs_resp_build
    import mcs_pkg::*;
(
    input  logic [5:0]  idx,
    input  logic        ok,
    input  logic [31:0] word,
    output resp_t       rsp
);
    always_comb begin
        rsp.bytes = {RESP_W{1'b1}};
        rsp.len   = 3'd1;
        rsp.busy  = 1'b0;
        if (!ok) begin
            rsp.bytes[RESP_W-1 -: 8] = BYTE_CMD_FAIL;
        end else if (idx == IDX_IFCOND || idx == IDX_OCR) begin
            rsp.bytes = {BYTE_LONG_HDR, word};
            rsp.len   = 3'd5;
        end else if (idx == IDX_STATUS) begin
            rsp.bytes[RESP_W-1 -: 16] = word[31:16];
            rsp.len   = 3'd2;
        end else begin
            rsp.bytes[RESP_W-1 -: 8] = word[31:24];
            rsp.busy  = is_busy_cmd(idx);
        end
    end
endmodule

// File: rtl/mcs_resp_queue.sv
`timescale 1ns/1ps
module mcs_resp_queue
    import mcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [RESP_W-1:0] load_bytes,
    input  logic [2:0]        load_len,
    input  logic              shift,
    output logic [7:0]        head,
    output logic              empty
);
    logic [RESP_W-1:0] q;
    logic [2:0]        n;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= {RESP_W{1'b1}};
            n <= 3'd0;
        end else if (load) begin
            q <= load_bytes;
            n <= load_len;
        end else if (shift && n != 3'd0) begin
            q <= {q[RESP_W-9:0], BYTE_IDLE};
            n <= n - 3'd1;
        end
    end

    assign head  = q[RESP_W-1 -: 8];
    assign empty = (n == 3'd0);
endmodule

// File: rtl/mcs_crc16.sv
`timescale 1ns/1ps
module mcs_crc16
    import mcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= 16'h0000;
        else if (en)    crc <= crc16_byte(crc, data);
    end
endmodule

// File: rtl/mcard_spi_engine.sv
`timescale 1ns/1ps
module mcard_spi_engine
    import mcs_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    output logic        be_cmd_req,
    output logic [5:0]  be_cmd_idx,
    output logic [31:0] be_cmd_arg,
    input  logic        be_cmd_ok,
    input  logic [31:0] be_cmd_resp,
    output logic        be_rd_req,
    input  logic [7:0]  be_rd_data,
    input  logic        be_rd_ready,
    input  logic        be_rd_last,
    output logic        be_wr_req,
    output logic [7:0]  be_wr_data,
    input  logic        be_wr_last
);
    localparam int CNT_W = $clog2(BLOCK_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLOCK_BYTES);

    mode_e             mode_q, mode_d;
    logic [2:0]        argn_q, argn_d;
    logic [5:0]        cmd_q, cmd_d;
    logic [31:0]       arg_q, arg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              pos_q, pos_d;
    logic              pre_q, pre_d;
    logic              busy_q, busy_d;

    logic              in_read, abort;
    resp_t             dec;
    logic              q_load, q_shift, q_empty;
    logic [RESP_W-1:0] q_bytes;
    logic [2:0]        q_len;
    logic [7:0]        q_head;
    logic              crc_clr, crc_en;
    logic [15:0]       crc;

    mcs_resp_build u_build (
        .idx  (cmd_q),
        .ok   (be_cmd_ok),
        .word (be_cmd_resp),
        .rsp  (dec)
    );

    mcs_resp_queue u_queue (
        .clk        (clk),
        .rst        (rst),
        .load       (q_load),
        .load_bytes (q_bytes),
        .load_len   (q_len),
        .shift      (q_shift),
        .head       (q_head),
        .empty      (q_empty)
    );

    mcs_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  (crc_clr),
        .en   (crc_en),
        .data (be_rd_data),
        .crc  (crc)
    );

    assign in_read    = (mode_q == M_PREP) || (mode_q == M_START) ||
                        (mode_q == M_READ) || (mode_q == M_RDCRC);
    assign abort      = rx_valid && in_read && (rx_byte == BYTE_STOP_CMD);
    assign be_wr_data = rx_byte;

    always_comb begin
        mode_d     = mode_q;
        argn_d     = argn_q;
        cmd_d      = cmd_q;
        arg_d      = arg_q;
        cnt_d      = cnt_q;
        pos_d      = pos_q;
        pre_d      = pre_q;
        busy_d     = busy_q;
        tx_byte    = BYTE_IDLE;
        be_cmd_req = 1'b0;
        be_cmd_idx = cmd_q;
        be_cmd_arg = arg_q;
        be_rd_req  = 1'b0;
        be_wr_req  = 1'b0;
        q_load     = 1'b0;
        q_shift    = 1'b0;
        q_bytes    = dec.bytes;
        q_len      = dec.len;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;

        if (abort) begin
            mode_d = M_ARG;
            cmd_d  = rx_byte[5:0];
            argn_d = 3'd0;
            cnt_d  = '0;
            pos_d  = 1'b0;
            pre_d  = 1'b1;
        end else if (rx_valid) begin
            case (mode_q)
                M_CMD: begin
                    if (rx_byte == TOK_BLOCK || rx_byte == TOK_MULTI_WR) begin
                        mode_d = M_WRITE;
                        cnt_d  = '0;
                    end else if (rx_byte == TOK_END_WR) begin
                        be_cmd_req = 1'b1;
                        be_cmd_idx = IDX_STOP;
                        be_cmd_arg = 32'h0;
                        q_load     = 1'b1;
                        q_bytes    = {RESP_W{1'b1}};
                        q_bytes[RESP_W-1 -: 8] = be_cmd_ok ? BYTE_IDLE : 8'h00;
                        q_len      = 3'd1;
                        busy_d     = 1'b0;
                        pre_d      = 1'b0;
                        mode_d     = M_RESP;
                    end else if (rx_byte != BYTE_IDLE) begin
                        cmd_d  = rx_byte[5:0];
                        argn_d = 3'd0;
                        mode_d = M_ARG;
                    end
                end
                M_ARG: begin
                    if (argn_q == 3'd4) begin
                        be_cmd_req = 1'b1;
                        q_load     = 1'b1;
                        busy_d     = dec.busy;
                        mode_d     = M_RESP;
                    end else begin
                        arg_d  = {arg_q[23:0], rx_byte};
                        argn_d = argn_q + 3'd1;
                    end
                end
                M_RESP: begin
                    if (pre_q) begin
                        pre_d = 1'b0;
                    end else if (!q_empty) begin
                        tx_byte = q_head;
                        q_shift = 1'b1;
                    end else if (busy_q) begin
                        busy_d = 1'b0;
                        mode_d = M_CMD;
                    end else if (be_rd_ready) begin
                        mode_d = M_START;
                    end else begin
                        mode_d = M_CMD;
                    end
                end
                M_PREP: begin
                    mode_d = M_START;
                end
                M_START: begin
                    tx_byte = TOK_BLOCK;
                    crc_clr = 1'b1;
                    cnt_d   = '0;
                    mode_d  = M_READ;
                end
                M_READ: begin
                    be_rd_req = 1'b1;
                    crc_en    = 1'b1;
                    tx_byte   = be_rd_data;
                    cnt_d     = cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST || be_rd_last) begin
                        mode_d = M_RDCRC;
                        pos_d  = 1'b0;
                    end
                end
                M_RDCRC: begin
                    tx_byte = pos_q ? crc[7:0] : crc[15:8];
                    if (pos_q) begin
                        mode_d = (cnt_q == CNT_FULL && cmd_q != IDX_SINGLE_RD) ? M_PREP : M_CMD;
                        cnt_d  = '0;
                        pos_d  = 1'b0;
                    end else begin
                        pos_d = 1'b1;
                    end
                end
                M_WRITE: begin
                    be_wr_req = 1'b1;
                    tx_byte   = rx_byte;
                    cnt_d     = cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST || be_wr_last) begin
                        mode_d = M_WRCRC;
                        pos_d  = 1'b0;
                        cnt_d  = '0;
                    end
                end
                M_WRCRC: begin
                    if (pos_q) begin
                        q_load  = 1'b1;
                        q_bytes = {RESP_W{1'b1}};
                        q_bytes[RESP_W-1 -: 8] = BYTE_WR_ACCEPT;
                        q_len   = 3'd1;
                        busy_d  = 1'b0;
                        pre_d   = 1'b0;
                        pos_d   = 1'b0;
                        mode_d  = M_RESP;
                    end else begin
                        pos_d = 1'b1;
                    end
                end
                default: begin
                    mode_d = M_CMD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_CMD;
            argn_q <= 3'd0;
            cmd_q  <= 6'd0;
            arg_q  <= 32'h0;
            cnt_q  <= '0;
            pos_q  <= 1'b0;
            pre_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            argn_q <= argn_d;
            cmd_q  <= cmd_d;
            arg_q  <= arg_d;
            cnt_q  <= cnt_d;
            pos_q  <= pos_d;
            pre_q  <= pre_d;
            busy_q <= busy_d;
        end
    end
endmodule

// File: rtl/mcs_engine_chk.sv
`timescale 1ns/1ps
module mcs_engine_chk
    import mcs_pkg::*;
#(
    parameter int BLK = 512
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         rx_valid,
    input logic [7:0]                   rx_byte,
    input logic                         be_cmd_req,
    input logic [5:0]                   be_cmd_idx,
    input logic                         be_rd_req,
    input logic                         be_wr_req,
    input mode_e                        mode_q,
    input logic [$clog2(BLK+1)-1:0]     cnt_q
);
    localparam int CW = $clog2(BLK + 1);

    // R1
    reset_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mode_q == M_CMD);

    // R2
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({be_cmd_req, be_rd_req, be_wr_req}));

    // R11
    write_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        be_wr_req |-> rx_valid);

    // R10
    stop_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_byte == 8'h4C &&
         (mode_q == M_PREP || mode_q == M_START || mode_q == M_READ || mode_q == M_RDCRC))
        |-> !be_rd_req);

    // R8
    block_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(BLK));

    // R12
    end_write_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode_q == M_CMD && rx_byte == 8'hFD) |-> (be_cmd_req && be_cmd_idx == 6'd12));
endmodule

bind mcard_spi_engine mcs_engine_chk #(.BLK(BLOCK_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .be_cmd_req (be_cmd_req),
    .be_cmd_idx (be_cmd_idx),
    .be_rd_req  (be_rd_req),
    .be_wr_req  (be_wr_req),
    .mode_q     (mode_q),
    .cnt_q      (cnt_q)
);

// File: tb/sim_mcard_spi_engine.sv
`timescale 1ns/1ps
module sim_mcard_spi_engine;
    localparam int BLK = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'hFF;
    logic [7:0]  tx_byte;
    logic        be_cmd_req, be_rd_req, be_wr_req;
    logic [5:0]  be_cmd_idx;
    logic [31:0] be_cmd_arg;
    logic [7:0]  be_wr_data;
    logic        be_cmd_ok = 1'b1;
    logic [31:0] be_cmd_resp = 32'h0;
    logic [7:0]  be_rd_data;
    logic        be_rd_ready, be_rd_last, be_wr_last;

    int rd_prog = 0;
    int wr_lim  = 100;
    int rd_ptr, rd_avail, wr_ptr, ncmd;
    logic [5:0]  last_idx;
    logic [31:0] last_arg;
    logic [7:0]  wr_mem [64];

    int vectors = 0;
    int miss    = 0;

    always #2 clk = ~clk;

    mcard_spi_engine #(.BLOCK_BYTES(BLK)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte),
        .be_cmd_req(be_cmd_req), .be_cmd_idx(be_cmd_idx), .be_cmd_arg(be_cmd_arg),
        .be_cmd_ok(be_cmd_ok), .be_cmd_resp(be_cmd_resp),
        .be_rd_req(be_rd_req), .be_rd_data(be_rd_data), .be_rd_ready(be_rd_ready),
        .be_rd_last(be_rd_last), .be_wr_req(be_wr_req), .be_wr_data(be_wr_data),
        .be_wr_last(be_wr_last)
    );

    function automatic logic [7:0] rdpat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] wrpat(input int i);
        return 8'((i * 13 + 5) & 255);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            fb = r[15] ^ d[b];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // behavioural storage back-end
    assign be_rd_data  = rdpat(rd_ptr);
    assign be_rd_ready = (rd_ptr < rd_avail);
    assign be_rd_last  = (rd_ptr == rd_avail - 1);
    assign be_wr_last  = (wr_ptr == wr_lim - 1);

    always @(posedge clk) begin
        if (rst) begin
            rd_ptr <= 0; rd_avail <= 0; wr_ptr <= 0; ncmd <= 0;
            last_idx <= 6'd0; last_arg <= 32'h0;
        end else begin
            if (be_cmd_req) begin
                last_idx <= be_cmd_idx;
                last_arg <= be_cmd_arg;
                ncmd     <= ncmd + 1;
                wr_ptr   <= 0;
                if (be_cmd_idx == 6'd12) rd_avail <= 0;
                else if (be_cmd_ok) begin
                    rd_ptr   <= 0;
                    rd_avail <= rd_prog;
                end
            end
            if (be_rd_req) rd_ptr <= rd_ptr + 1;
            if (be_wr_req) begin
                wr_mem[wr_ptr % 64] <= be_wr_data;
                wr_ptr <= wr_ptr + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] got);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        #1 got = tx_byte;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic xchk(input string req, input logic [7:0] b, input logic [7:0] exp);
        logic [7:0] g;
        xfer(b, g);
        check(req, {24'h0, g}, {24'h0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] first, input logic [31:0] arg);
        xchk("R2", first, 8'hFF);
        for (int i = 3; i >= 0; i--) xchk("R2", arg[8*i +: 8], 8'hFF);
        xchk("R2", 8'h95, 8'hFF);
    endtask

    task automatic t_reset();
        check("R1", ncmd, 0);
        xchk("R1", 8'hFF, 8'hFF);
        xchk("R1", 8'hFF, 8'hFF);
        check("R1", ncmd, 0);
    endtask

    task automatic t_framing();
        be_cmd_ok = 1'b1; be_cmd_resp = 32'hA5C3_1E77; rd_prog = 0;
        send_cmd(8'hD0, 32'h1234_5678);
        check("R2", last_idx, 6'd16);
        check("R2", last_arg, 32'h1234_5678);
        check("R2", ncmd, 1);
        xchk("R5", 8'hFF, 8'hA5);
        xchk("R5", 8'hFF, 8'hFF);
        xchk("R5", 8'hFF, 8'hFF);
    endtask

    task automatic t_fail();
        be_cmd_ok = 1'b0; be_cmd_resp = 32'h8899_AABB; rd_prog = 0;
        send_cmd(8'h49, 32'h0);
        xchk("R3", 8'hFF, 8'h04);
        xchk("R3", 8'hFF, 8'hFF);
        be_cmd_ok = 1'b1;
    endtask

    task automatic t_long();
        be_cmd_resp = 32'hDEAD_BEEF; rd_prog = 0;
        send_cmd(8'h48, 32'h0000_01AA);
        check("R4", last_idx, 6'd8);
        xchk("R4", 8'hFF, 8'h01);
        xchk("R4", 8'hFF, 8'hDE);
        xchk("R4", 8'hFF, 8'hAD);
        xchk("R4", 8'hFF, 8'hBE);
        xchk("R4", 8'hFF, 8'hEF);
        xchk("R4", 8'hFF, 8'hFF);
        be_cmd_resp = 32'h4061_72C0;
        send_cmd(8'h7A, 32'h0);
        xchk("R4", 8'hFF, 8'h01);
        xchk("R4", 8'hFF, 8'h40);
        xchk("R4", 8'hFF, 8'h61);
        xchk("R4", 8'hFF, 8'h72);
        xchk("R4", 8'hFF, 8'hC0);
        xchk("R4", 8'hFF, 8'hFF);
    endtask

    task automatic t_status();
        be_cmd_resp = 32'h1234_5678; rd_prog = 0;
        send_cmd(8'h4D, 32'h0);
        xchk("R5", 8'hFF, 8'h12);
        xchk("R5", 8'hFF, 8'h34);
        xchk("R5", 8'hFF, 8'hFF);
        xchk("R5", 8'hFF, 8'hFF);
    endtask

    task automatic t_busy();
        be_cmd_resp = 32'h0000_0000; rd_prog = 3;
        send_cmd(8'h5C, 32'h0);
        xchk("R6", 8'hFF, 8'h00);
        xchk("R6", 8'hFF, 8'hFF);
        xchk("R6", 8'hFF, 8'hFF);
        xchk("R6", 8'hFF, 8'hFF);
        check("R6", rd_ptr, 0);
        rd_prog = 0;
        be_cmd_resp = 32'h3300_0000;
        send_cmd(8'h66, 32'h0);
        xchk("R6", 8'hFF, 8'h33);
        xchk("R6", 8'hFF, 8'hFF);
        xchk("R6", 8'hFF, 8'hFF);
    endtask

    task automatic read_block(input string req, input int first, input int n);
        logic [15:0] c;
        c = 16'h0;
        xchk(req, 8'hFF, 8'hFE);
        for (int i = 0; i < n; i++) begin
            xchk(req, 8'hFF, rdpat(first + i));
            c = ref_crc(c, rdpat(first + i));
        end
        xchk("R7", 8'hFF, c[15:8]);
        xchk("R7", 8'hFF, c[7:0]);
    endtask

    task automatic t_single_read();
        be_cmd_resp = 32'h0; rd_prog = 20;
        send_cmd(8'h51, 32'h0000_0200);
        xchk("R7", 8'hFF, 8'h00);
        xchk("R7", 8'hFF, 8'hFF);
        read_block("R7", 0, BLK);
        xchk("R9", 8'hFF, 8'hFF);
        xchk("R9", 8'hFF, 8'hFF);
        check("R9", rd_ptr, BLK);
    endtask

    task automatic t_short_read();
        be_cmd_resp = 32'h0; rd_prog = 5;
        send_cmd(8'h52, 32'h0);
        xchk("R8", 8'hFF, 8'h00);
        xchk("R8", 8'hFF, 8'hFF);
        read_block("R8", 0, 5);
        xchk("R8", 8'hFF, 8'hFF);
        xchk("R8", 8'hFF, 8'hFF);
    endtask

    task automatic t_multi_read();
        be_cmd_resp = 32'h0; rd_prog = 40;
        send_cmd(8'h52, 32'h0);
        xchk("R9", 8'hFF, 8'h00);
        xchk("R9", 8'hFF, 8'hFF);
        read_block("R9", 0, BLK);
        xchk("R9", 8'hFF, 8'hFF);
        read_block("R9", BLK, BLK);
        xchk("R9", 8'hFF, 8'hFF);
        read_block("R9", 2 * BLK, 40 - 2 * BLK);
        xchk("R9", 8'hFF, 8'hFF);
        xchk("R9", 8'hFF, 8'hFF);
        check("R9", rd_ptr, 40);
    endtask

    task automatic t_abort();
        be_cmd_resp = 32'h0; rd_prog = 40;
        send_cmd(8'h52, 32'h0);
        xchk("R10", 8'hFF, 8'h00);
        xchk("R10", 8'hFF, 8'hFF);
        xchk("R10", 8'hFF, 8'hFE);
        for (int i = 0; i < 3; i++) xchk("R10", 8'hFF, rdpat(i));
        be_cmd_resp = 32'h7F00_0000;
        xchk("R10", 8'h4C, 8'hFF);
        check("R10", rd_ptr, 3);
        for (int i = 0; i < 4; i++) xchk("R10", 8'h00, 8'hFF);
        xchk("R10", 8'h61, 8'hFF);
        check("R10", last_idx, 6'd12);
        check("R10", rd_ptr, 3);
        xchk("R10", 8'hFF, 8'hFF);
        xchk("R10", 8'hFF, 8'h7F);
        xchk("R10", 8'hFF, 8'hFF);
        xchk("R10", 8'hFF, 8'hFF);
    endtask

    task automatic t_write();
        be_cmd_resp = 32'h0; rd_prog = 0; wr_lim = 100;
        send_cmd(8'h58, 32'h0);
        xchk("R11", 8'hFF, 8'h00);
        xchk("R11", 8'hFF, 8'hFF);
        xchk("R11", 8'hFE, 8'hFF);
        for (int i = 0; i < BLK; i++) xchk("R11", wrpat(i), wrpat(i));
        xchk("R11", 8'h3C, 8'hFF);
        xchk("R11", 8'h3C, 8'hFF);
        xchk("R11", 8'hFF, 8'h05);
        xchk("R11", 8'hFF, 8'hFF);
        check("R11", wr_ptr, BLK);
        for (int i = 0; i < BLK; i++) check("R11", wr_mem[i], wrpat(i));
        send_cmd(8'h59, 32'h0);
        xchk("R11", 8'hFF, 8'h00);
        xchk("R11", 8'hFF, 8'hFF);
        wr_lim = 4;
        xchk("R11", 8'hFC, 8'hFF);
        for (int i = 0; i < 4; i++) xchk("R11", wrpat(i + 20), wrpat(i + 20));
        xchk("R11", 8'h3C, 8'hFF);
        xchk("R11", 8'h3C, 8'hFF);
        xchk("R11", 8'hFF, 8'h05);
        check("R11", wr_ptr, 4);
        for (int i = 0; i < 4; i++) check("R11", wr_mem[i], wrpat(i + 20));
        xchk("R11", 8'hFF, 8'hFF);
        wr_lim = 100;
    endtask

    task automatic t_end_write();
        int n0;
        n0 = ncmd;
        be_cmd_ok = 1'b1;
        xchk("R12", 8'hFD, 8'hFF);
        check("R12", ncmd, n0 + 1);
        check("R12", last_idx, 6'd12);
        check("R12", last_arg, 32'h0);
        xchk("R12", 8'hFF, 8'hFF);
        xchk("R12", 8'hFF, 8'hFF);
        be_cmd_ok = 1'b0;
        xchk("R12", 8'hFD, 8'hFF);
        be_cmd_ok = 1'b1;
        xchk("R12", 8'hFF, 8'h00);
        xchk("R12", 8'hFF, 8'hFF);
    endtask

    task automatic t_reset_mid();
        xchk("R1", 8'hFE, 8'hFF);
        do_reset();
        xchk("R1", 8'hAA, 8'hFF);
        check("R1", wr_ptr, 0);
        do_reset();
        xchk("R1", 8'hFF, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_framing();
        t_fail();
        t_long();
        t_status();
        t_busy();
        t_single_read();
        t_short_read();
        t_multi_read();
        t_abort();
        t_write();
        t_end_write();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule